// File: doc/BRIEF.md
# Carrier-Based Pulse-Width Modulator with Interval-Centred ADC Strobe

This block drives the gate of a switching converter from a counter carrier. It also issues a one-clock strobe that starts the current-sense ADC in the middle of the switch on-time or off-time. The carrier can be an up-counting sawtooth, a down-counting sawtooth or an up/down triangle. With a rising sawtooth the turn-on edge is fixed and the turn-off edge moves. With a falling sawtooth the turn-off edge is fixed and the turn-on edge moves. With the triangle, the on-time is centred on the count-zero point.

The control loop presents a duty word on `duty_in`, which acts as the shadow value. The active compare value takes that word only at carrier-dependent load points, so a duty change never splits a pulse. For the sawtooth carriers, the strobe position is recomputed every period from the compare value in force, so the sample keeps tracking the interval centre as the duty moves. For the triangle, the strobe is fixed to a carrier extreme. Carrier mode, carrier maximum and sampling position are taken only at a period boundary. The carrier maximum must be at least 2.

In every mode the gate output is high while the counter is below the active compare value. The gate and the strobe are decoded from registers, with no added pipeline stage.

Top module: `dpwm_adc_sync`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pwm_out`, `adc_trig_out` and `period_start_out` are all 0. `period_start_out` goes high in the cycle that follows the first clock edge after release.
- R2: Rising sawtooth (`mode_in`=00): the period is max+1 clocks. `pwm_out` is high for the first C clocks of the period, where C is the compare value, and low for the rest. The rising edge occurs only at the period start.
- R3: Falling sawtooth (`mode_in`=01): the period is max+1 clocks. `pwm_out` is low for the first max+1-C clocks and high for the last C clocks, so it falls only at a period start.
- R4: Triangle (`mode_in`=1x): the period is 2*max clocks. `pwm_out` is high for 2C-1 clocks: the first C clocks and the last C-1 clocks of the period.
- R5: In the sawtooth modes, a change of `duty_in` during a period does not affect that period. It takes effect from the next period start.
- R6: Sawtooth with on-centre sampling (`samp_off_in`=0): the strobe fires at count floor(C/2). In clock offsets from the period start, that is floor(C/2) for the rising sawtooth and max-floor(C/2) for the falling sawtooth.
- R7: Sawtooth with off-centre sampling (`samp_off_in`=1): the strobe fires at count floor((C+max)/2). In clock offsets, that is floor((C+max)/2) for the rising sawtooth and max-floor((C+max)/2) for the falling sawtooth.
- R8: When C=0 the output stays low for the whole period. When C>max it stays high for the whole period. If the selected interval is empty, the strobe fires at count floor(max/2).
- R9: In triangle mode the strobe fires at count zero (period offset 0) with on-centre sampling, and at the peak count (offset max) with off-centre sampling, whatever the duty value.
- R10: In triangle mode with on-centre sampling, the compare value loads at the peak, so a duty change made at the period start reshapes the falling half of that period. With off-centre sampling it loads only at count zero.
- R11: Changes of `mode_in` and `max_in` during a period take effect only at the next period start.
- R12: `adc_trig_out` pulses exactly once per period and `period_start_out` exactly once per period, each for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_in | input | W | Duty word (shadow value) |
| max_in | input | W | Carrier maximum count, 2 or more |
| mode_in | input | 2 | 00 rising sawtooth, 01 falling sawtooth, 1x triangle |
| samp_off_in | input | 1 | 0 samples at the on-interval centre, 1 at the off-interval centre |
| pwm_out | output | 1 | Gate drive |
| adc_trig_out | output | 1 | One-clock ADC start strobe |
| period_start_out | output | 1 | One-clock pulse in the first cycle of each period |

## Verification
A counter or direction flag that has gone wrong shows up within one period as a wrong period length, or as a second or missing `period_start_out` pulse. A compare value loaded at the wrong point shows up in the same period as the wrong high-time count, or as a strobe at the wrong offset. A stale mode or sampling-position register misplaces the pulse edges or the strobe in the very next period. Each scenario therefore measures whole periods at the ports: length, high count, first and last high offsets, and strobe offset and count.

// File: rtl/dpwm_adc_sync.sv
module dpwm_adc_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_in,
  input  logic [W-1:0] max_in,
  input  logic [1:0]   mode_in,
  input  logic         samp_off_in,
  output logic         pwm_out,
  output logic         adc_trig_out,
  output logic         period_start_out
);
  localparam logic [1:0]   M_RISE = 2'b00;
  localparam logic [1:0]   M_FALL = 2'b01;
  localparam logic [W-1:0] ONE    = 1;

  logic [W-1:0] cnt_q, max_q, cmp_q;
  logic [1:0]   mode_q;
  logic         soff_q, dn_q, pst_q, act_q;

  wire tri_q = mode_q[1];
  wire wrap  = (mode_q == M_RISE) ? (cnt_q >= max_q) :
               (mode_q == M_FALL) ? (cnt_q == '0)    :
               (dn_q && cnt_q == ONE);

  wire          empty = soff_q ? (cmp_q > max_q) : (cmp_q == '0);
  wire [W:0]    mid_sum = {1'b0, cmp_q} + {1'b0, max_q};
  wire [W:0]    tpos = empty  ? {2'b00, max_q[W-1:1]} :
                       soff_q ? (mid_sum >> 1) : {2'b00, cmp_q[W-1:1]};
  wire          hit = tri_q ? (soff_q ? (cnt_q == max_q && !dn_q) : (cnt_q == '0))
                            : ({1'b0, cnt_q} == tpos);

  assign pwm_out          = cnt_q < cmp_q;
  assign adc_trig_out     = act_q && hit;
  assign period_start_out = pst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      max_q  <= '0;
      cmp_q  <= '0;
      mode_q <= M_RISE;
      soff_q <= 1'b0;
      dn_q   <= 1'b0;
      pst_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      act_q <= 1'b1;
      pst_q <= wrap;
      if (wrap) begin
        mode_q <= mode_in;
        max_q  <= max_in;
        soff_q <= samp_off_in;
        dn_q   <= 1'b0;
        cnt_q  <= (mode_in == M_FALL) ? max_in : '0;
        if (!mode_in[1] || samp_off_in) cmp_q <= duty_in;
      end else if (mode_q == M_RISE) begin
        cnt_q <= cnt_q + ONE;
      end else if (mode_q == M_FALL) begin
        cnt_q <= cnt_q - ONE;
      end else if (dn_q) begin
        cnt_q <= cnt_q - ONE;
      end else if (cnt_q == max_q) begin
        dn_q  <= 1'b1;
        cnt_q <= cnt_q - ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
        if (!soff_q && cnt_q == max_q - ONE) cmp_q <= duty_in;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!adc_trig_out && !period_start_out && !pwm_out));

  assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RISE && $rose(pwm_out)) |-> period_start_out);

  assert_fall_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FALL && $fell(pwm_out)) |-> period_start_out);

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= max_q);

  assert_tri_on_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_q && !soff_q && adc_trig_out) |-> period_start_out);

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start_out |-> ($stable(mode_q) && $stable(max_q) && $stable(soff_q)));

  assert_trig_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_out |=> (!adc_trig_out || period_start_out));

  assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_out |=> !period_start_out);
endmodule

// File: tb/tb_dpwm_adc_sync.sv
module tb_dpwm_adc_sync;
  localparam int W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] duty_in = '0, max_in = '0;
  logic [1:0] mode_in = 2'b00;
  logic samp_off_in = 1'b0;
  logic pwm_out, adc_trig_out, period_start_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpwm_adc_sync #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .max_in(max_in),
    .mode_in(mode_in), .samp_off_in(samp_off_in), .pwm_out(pwm_out),
    .adc_trig_out(adc_trig_out), .period_start_out(period_start_out));

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic setup(input logic [1:0] m, input int mx, input int d, input logic so);
    mode_in = m; max_in = W'(mx); duty_in = W'(d); samp_off_in = so;
  endtask

  task automatic measure(input bit wait_start, output int len, output int hi,
                         output int fh, output int lh, output int tpos, output int tcnt);
    int i;
    if (wait_start) begin
      do step(); while (!period_start_out);
    end
    len = 0; hi = 0; fh = -1; lh = -1; tpos = -1; tcnt = 0; i = 0;
    do begin
      if (pwm_out) begin
        hi++;
        if (fh < 0) fh = i;
        lh = i;
      end
      if (adc_trig_out) begin
        tcnt++;
        tpos = i;
      end
      step();
      i++;
    end while (!period_start_out);
    len = i;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(int'(pwm_out), 0, "R1", "pwm in reset");
    chk(int'(adc_trig_out), 0, "R1", "trig in reset");
    chk(int'(period_start_out), 0, "R1", "pstart in reset");
    setup(2'b00, 9, 4, 1'b0);
    rst_n = 1'b1;
    #0;
    chk(int'(period_start_out), 0, "R1", "pstart before first edge");
    chk(int'(adc_trig_out), 0, "R1", "trig before first edge");
    step();
    chk(int'(period_start_out), 1, "R1", "pstart after first edge");
  endtask

  task automatic t_rise();
    int len, hi, fh, lh, tp, tc;
    setup(2'b00, 9, 4, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(len, 10, "R2", "rise period");
    chk(hi, 4, "R2", "rise high count");
    chk(fh, 0, "R2", "rise first high");
    chk(lh, 3, "R2", "rise last high");
    chk(tp, 2, "R6", "rise on-centre trig");
    chk(tc, 1, "R12", "rise trig count");
    setup(2'b00, 9, 4, 1'b1);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(tp, 6, "R7", "rise off-centre trig");
    chk(tc, 1, "R12", "rise off trig count");
  endtask

  task automatic t_fall();
    int len, hi, fh, lh, tp, tc;
    setup(2'b01, 9, 4, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(len, 10, "R3", "fall period");
    chk(hi, 4, "R3", "fall high count");
    chk(fh, 6, "R3", "fall first high");
    chk(lh, 9, "R3", "fall last high");
    chk(tp, 7, "R6", "fall on-centre trig");
    setup(2'b01, 9, 4, 1'b1);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(tp, 3, "R7", "fall off-centre trig");
    chk(tc, 1, "R12", "fall trig count");
  endtask

  task automatic t_tri();
    int len, hi, fh, lh, tp, tc;
    setup(2'b10, 6, 3, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    measure(0, len, hi, fh, lh, tp, tc);
    chk(len, 12, "R4", "tri period");
    chk(hi, 5, "R4", "tri high count");
    chk(fh, 0, "R4", "tri first high");
    chk(lh, 11, "R4", "tri last high");
    chk(tp, 0, "R9", "tri on-centre trig");
    setup(2'b10, 6, 5, 1'b1);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(hi, 9, "R4", "tri high count C=5");
    chk(tp, 6, "R9", "tri off-centre trig");
    chk(tc, 1, "R12", "tri trig count");
  endtask

  task automatic t_empty();
    int len, hi, fh, lh, tp, tc;
    setup(2'b00, 9, 0, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(hi, 0, "R8", "zero duty high count");
    chk(tp, 4, "R8", "zero duty on-centre trig");
    setup(2'b00, 9, 12, 1'b1);
    measure(1, len, hi, fh, lh, tp, tc);
    chk(hi, 10, "R8", "full duty high count");
    chk(tp, 4, "R8", "full duty off-centre trig");
  endtask

  task automatic t_shadow();
    int len, hi, fh, lh, tp, tc;
    setup(2'b00, 9, 4, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    duty_in = W'(7);
    measure(0, len, hi, fh, lh, tp, tc);
    chk(hi, 4, "R5", "duty change same period");
    chk(tp, 2, "R5", "trig same period");
    measure(0, len, hi, fh, lh, tp, tc);
    chk(hi, 7, "R5", "duty change next period");
    chk(tp, 3, "R6", "trig tracks new duty");
  endtask

  task automatic t_tri_load();
    int len, hi, fh, lh, tp, tc;
    setup(2'b10, 6, 2, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    measure(0, len, hi, fh, lh, tp, tc);
    duty_in = W'(5);
    measure(0, len, hi, fh, lh, tp, tc);
    chk(hi, 6, "R10", "on-centre peak load");
    setup(2'b10, 6, 2, 1'b1);
    measure(1, len, hi, fh, lh, tp, tc);
    duty_in = W'(5);
    measure(0, len, hi, fh, lh, tp, tc);
    chk(hi, 3, "R10", "off-centre no peak load");
    measure(0, len, hi, fh, lh, tp, tc);
    chk(hi, 9, "R10", "off-centre zero load");
  endtask

  task automatic t_boundary();
    int len, hi, fh, lh, tp, tc;
    setup(2'b00, 9, 4, 1'b0);
    measure(1, len, hi, fh, lh, tp, tc);
    mode_in = 2'b01; max_in = W'(5);
    measure(0, len, hi, fh, lh, tp, tc);
    chk(len, 10, "R11", "old max kept");
    chk(fh, 0, "R11", "old mode kept");
    measure(0, len, hi, fh, lh, tp, tc);
    chk(len, 6, "R11", "new max applied");
    chk(fh, 2, "R11", "new mode applied");
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_tri();
    t_empty();
    t_shadow();
    t_tri_load();
    t_boundary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule